// File: doc/BRIEF.md
# Two-Byte Result Port with Receiver Handshake

This block presents a 14-bit conversion result (12 magnitude bits, a sign flag and an over-range flag) on an 8-bit bus, one byte at a time. It has two ways of working. In the passive way, an external reader pulls a chip select and a byte select low, and the block drives the chosen byte. In the active way, the block drives the same three control lines itself. It pushes the high byte and then the low byte into a byte-wide receiver, such as a serial transmitter's holding register, and paces each byte by the receiver's ready line.

Each control line is split into an input, an output and a shared output enable (`ctl_oe_o`). The pad ring outside the block builds the bidirectional pins from these. The bus works the same way: a data value plus an enable. `clk` runs at twice the rate of the internal conversion clock. After reset, the internal clock edges alternate rise, fall, rise, and so on, starting with a rise. One "tick" below is one `clk` cycle, which is half an internal clock period.

The active transfer is built around a state machine with these states: `ST_IDLE`, `ST_WAIT_SEND`, `ST_ARMED`, `ST_HI_LOAD`, `ST_HI_HOLD`, `ST_HI_GAP`, `ST_LO_LOAD`, `ST_LO_HOLD` and `ST_DONE`. Its transitions are:

- IDLE to WAIT_SEND when a transfer is triggered.
- WAIT_SEND to ARMED on a fall edge with SEND high.
- ARMED to HI_LOAD on the next edge, which is a rise.
- HI_LOAD to HI_HOLD on its second rise.
- HI_HOLD to HI_GAP on a fall edge with SEND high.
- HI_GAP to LO_LOAD on the next rise.
- LO_LOAD to LO_HOLD on its second rise.
- LO_HOLD to DONE on a fall edge with SEND high.
- DONE to IDLE on the next rise.

Top module: `result_byte_port`

## Requirements
- R1: The high byte is {2'b00, over-range, sign, data[11:8]}, with data[8] at bit 0. The low byte is data[7:0].
- R2: When idle with `mode_i` low, `ctl_oe_o` is 0. The bus is driven only while `ce_n_i` is low and at least one byte select is low. If both byte selects are low, the high byte wins. Otherwise `bus_oe_o` is 0.
- R3: With `mode_i` held high, a result latched by `new_result_i` while idle is then sent automatically.
- R4: A rising edge of `mode_i` while idle starts a transfer of the held result. If the edge comes while `new_result_i` is high, the start waits until `new_result_i` is low, and the new result is the one sent. `mode_i` is ignored while a transfer is in progress.
- R5: No load pulse starts while SEND is low. SEND is sampled only on fall edges.
- R6: With SEND high, each load strobe (`ce_n_o`) is low for exactly 2 ticks. Each byte enable stays low exactly one tick longer than its byte is driven: 4 ticks against 3.
- R7: If SEND is low at a fall edge during a hold, the byte enable stays low and the byte stays on the bus. After SEND returns high, the bus is released at a fall edge, and the enable rises one tick later.
- R8: The high byte is sent first, flagged by `hben_n_o` low. The low byte follows, with `lben_n_o` and `ce_n_o` falling together. The two enables are never low together.
- R9: New results are not latched while a transfer is in progress. Such a result is lost.
- R10: After a transfer, all three control outputs are high. They stay driven (`ctl_oe_o`=1) while `mode_i` is high, and become inputs when `mode_i` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | High: active transfers; rising edge triggers one |
| send_i | input | 1 | Receiver ready |
| new_result_i | input | 1 | Strobe carrying a new result to latch |
| conv_data_i | input | 12 | Result magnitude bits |
| conv_pol_i | input | 1 | Result sign flag |
| conv_ovr_i | input | 1 | Result over-range flag |
| ce_n_i | input | 1 | Chip select from the reader, passive mode, active low |
| hben_n_i | input | 1 | High byte select, passive mode, active low |
| lben_n_i | input | 1 | Low byte select, passive mode, active low |
| ce_n_o | output | 1 | Load strobe to the receiver, active mode, active low |
| hben_n_o | output | 1 | High byte flag, active mode, active low |
| lben_n_o | output | 1 | Low byte flag, active mode, active low |
| ctl_oe_o | output | 1 | Control lines act as outputs |
| bus_o | output | 8 | Byte bus data |
| bus_oe_o | output | 1 | Byte bus output enable |

## Verification
The bench stalls the receiver for random lengths after each load strobe. A design that releases the byte early, or that drops the enable together with the data, breaks the rule that an enable outlasts its byte by exactly one tick.

Other cases target specific timing and storage faults:
- A mode edge that arrives while a result is being latched. A design that starts at once would send the stale value.
- A result arriving in the middle of a transfer. A design that keeps latching would corrupt the transfer or a later one.
- A mode toggle during a transfer. A design that does not ignore it would start a second, unrequested transfer.
- SEND held low at entry. A design that samples SEND on the wrong edge, or not at all, would pulse the load strobe too early.

Random passive-mode selects check the byte layout and the rule that the high byte wins.

// File: rtl/result_port_pkg.sv
package result_port_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_SEND,
        ST_ARMED,
        ST_HI_LOAD,
        ST_HI_HOLD,
        ST_HI_GAP,
        ST_LO_LOAD,
        ST_LO_HOLD,
        ST_DONE
    } xfer_state_e;

endpackage

// File: rtl/xfer_trigger.sv
module xfer_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic new_result_i,
    input  logic idle_i,
    output logic start_o
);

    logic mode_q;
    logic pend_q;
    logic pend_d;
    logic mode_rise;
    logic want;

    assign mode_rise = mode_i & ~mode_q;
    assign want      = mode_rise | pend_q;
    // A latch in progress postpones the start by at least one tick.
    assign start_o   = idle_i & want & ~new_result_i;

    always_comb begin
        pend_d = pend_q;
        if (!idle_i) begin
            pend_d = 1'b0;
        end else if (start_o) begin
            pend_d = 1'b0;
        end else if (want || (new_result_i && mode_i)) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            mode_q <= mode_i;
            pend_q <= pend_d;
        end
    end

    // R4
    deferred_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && new_result_i) |-> !start_o);

endmodule

// File: rtl/result_hold.sv
module result_hold #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    output logic [BYTE_W-1:0] hi_byte_o,
    output logic [BYTE_W-1:0] lo_byte_o
);

    localparam int HI_BITS = DATA_W - BYTE_W;
    localparam int HI_USED = HI_BITS + 2;

    logic [DATA_W-1:0] data_q;
    logic              pol_q;
    logic              ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pol_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (load_i) begin
            data_q <= data_i;
            pol_q  <= pol_i;
            ovr_q  <= ovr_i;
        end
    end

    generate
        if (HI_USED < BYTE_W) begin : g_pad
            assign hi_byte_o = {{(BYTE_W-HI_USED){1'b0}}, ovr_q, pol_q, data_q[DATA_W-1:BYTE_W]};
        end else begin : g_full
            assign hi_byte_o = {ovr_q, pol_q, data_q[DATA_W-1:BYTE_W]};
        end
    endgenerate

    assign lo_byte_o = data_q[BYTE_W-1:0];

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import result_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic send_i,
    output logic idle_o,
    output logic ce_n_o,
    output logic hb_n_o,
    output logic lb_n_o,
    output logic hi_drive_o,
    output logic lo_drive_o
);

    xfer_state_e state_q;
    xfer_state_e state_d;
    logic        fall_q;

    // fall_q high: the coming edge is an internal-clock fall edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fall_q  <= ~fall_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i)            state_d = ST_WAIT_SEND;
            ST_WAIT_SEND: if (fall_q && send_i)   state_d = ST_ARMED;
            ST_ARMED:                             state_d = ST_HI_LOAD;
            ST_HI_LOAD:   if (!fall_q)            state_d = ST_HI_HOLD;
            ST_HI_HOLD:   if (fall_q && send_i)   state_d = ST_HI_GAP;
            ST_HI_GAP:                            state_d = ST_LO_LOAD;
            ST_LO_LOAD:   if (!fall_q)            state_d = ST_LO_HOLD;
            ST_LO_HOLD:   if (fall_q && send_i)   state_d = ST_DONE;
            ST_DONE:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ce_n_o     = 1'b1;
        hb_n_o     = 1'b1;
        lb_n_o     = 1'b1;
        hi_drive_o = 1'b0;
        lo_drive_o = 1'b0;
        unique case (state_q)
            ST_HI_LOAD: begin
                ce_n_o     = 1'b0;
                hb_n_o     = 1'b0;
                hi_drive_o = 1'b1;
            end
            ST_HI_HOLD: begin
                hb_n_o     = 1'b0;
                hi_drive_o = 1'b1;
            end
            ST_HI_GAP: begin
                hb_n_o = 1'b0;
            end
            ST_LO_LOAD: begin
                ce_n_o     = 1'b0;
                lb_n_o     = 1'b0;
                lo_drive_o = 1'b1;
            end
            ST_LO_HOLD: begin
                lb_n_o     = 1'b0;
                lo_drive_o = 1'b1;
            end
            ST_DONE: begin
                lb_n_o = 1'b0;
            end
            default: begin
                ce_n_o = 1'b1;
            end
        endcase
    end

    assign idle_o = (state_q == ST_IDLE);

    // R6
    hi_load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_LOAD && $past(state_q) != ST_HI_LOAD) |=> state_q == ST_HI_LOAD);

    // R6
    lo_load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_LOAD && $past(state_q) != ST_LO_LOAD) |=> state_q == ST_LO_LOAD);

    // R7
    hi_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_HOLD && !send_i) |=> state_q == ST_HI_HOLD);

    // R5
    wait_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SEND && !send_i) |=> state_q == ST_WAIT_SEND);

    // R8
    lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO_LOAD && $past(state_q) != ST_LO_LOAD) |-> $past(state_q) == ST_HI_GAP);

endmodule

// File: rtl/bus_select.sv
module bus_select #(
    parameter int BYTE_W = 8
) (
    input  logic              mode_i,
    input  logic              idle_i,
    input  logic              ce_n_i,
    input  logic              hben_n_i,
    input  logic              lben_n_i,
    input  logic              fsm_ce_n,
    input  logic              fsm_hb_n,
    input  logic              fsm_lb_n,
    input  logic              fsm_hi_drv,
    input  logic              fsm_lo_drv,
    input  logic [BYTE_W-1:0] hi_byte_i,
    input  logic [BYTE_W-1:0] lo_byte_i,
    output logic              ce_n_o,
    output logic              hben_n_o,
    output logic              lben_n_o,
    output logic              ctl_oe_o,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o
);

    logic active;
    logic pick_hi;
    logic pick_lo;

    assign active   = mode_i | ~idle_i;
    assign ctl_oe_o = active;
    assign ce_n_o   = fsm_ce_n;
    assign hben_n_o = fsm_hb_n;
    assign lben_n_o = fsm_lb_n;

    always_comb begin
        if (active) begin
            pick_hi = fsm_hi_drv;
            pick_lo = fsm_lo_drv;
        end else begin
            pick_hi = ~ce_n_i & ~hben_n_i;
            pick_lo = ~ce_n_i & hben_n_i & ~lben_n_i;
        end
    end

    assign bus_oe_o = pick_hi | pick_lo;
    assign bus_o    = pick_hi ? hi_byte_i : (pick_lo ? lo_byte_i : '0);

endmodule

// File: rtl/result_byte_port.sv
module result_byte_port #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              send_i,
    input  logic              new_result_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              conv_pol_i,
    input  logic              conv_ovr_i,
    input  logic              ce_n_i,
    input  logic              hben_n_i,
    input  logic              lben_n_i,
    output logic              ce_n_o,
    output logic              hben_n_o,
    output logic              lben_n_o,
    output logic              ctl_oe_o,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o
);

    logic              idle;
    logic              start;
    logic              f_ce_n;
    logic              f_hb_n;
    logic              f_lb_n;
    logic              f_hi;
    logic              f_lo;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    xfer_trigger u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .new_result_i (new_result_i),
        .idle_i       (idle),
        .start_o      (start)
    );

    result_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (new_result_i & idle),
        .data_i    (conv_data_i),
        .pol_i     (conv_pol_i),
        .ovr_i     (conv_ovr_i),
        .hi_byte_o (hi_byte),
        .lo_byte_o (lo_byte)
    );

    xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .send_i     (send_i),
        .idle_o     (idle),
        .ce_n_o     (f_ce_n),
        .hb_n_o     (f_hb_n),
        .lb_n_o     (f_lb_n),
        .hi_drive_o (f_hi),
        .lo_drive_o (f_lo)
    );

    bus_select #(.BYTE_W(BYTE_W)) u_bus (
        .mode_i     (mode_i),
        .idle_i     (idle),
        .ce_n_i     (ce_n_i),
        .hben_n_i   (hben_n_i),
        .lben_n_i   (lben_n_i),
        .fsm_ce_n   (f_ce_n),
        .fsm_hb_n   (f_hb_n),
        .fsm_lb_n   (f_lb_n),
        .fsm_hi_drv (f_hi),
        .fsm_lo_drv (f_lo),
        .hi_byte_i  (hi_byte),
        .lo_byte_i  (lo_byte),
        .ce_n_o     (ce_n_o),
        .hben_n_o   (hben_n_o),
        .lben_n_o   (lben_n_o),
        .ctl_oe_o   (ctl_oe_o),
        .bus_o      (bus_o),
        .bus_oe_o   (bus_oe_o)
    );

    // R9
    held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable({hi_byte, lo_byte}));

    // R2
    direct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_oe_o && ce_n_i) |-> !bus_oe_o);

    // R8
    enables_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hben_n_o && !lben_n_o));

endmodule

// File: tb/result_byte_port_tb.sv
module result_byte_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        newr = 1'b0;
    logic [11:0] data = '0;
    logic        pol = 1'b0;
    logic        ovr = 1'b0;
    logic        ce_i = 1'b1;
    logic        hb_i = 1'b1;
    logic        lb_i = 1'b1;
    logic        ce_o, hb_o, lb_o, ctl_oe, bus_oe;
    logic [7:0]  bus;
    logic        send;
    logic        uart_rdy = 1'b1;
    logic        hold_send = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    assign send = uart_rdy & ~hold_send;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .send_i(send),
        .new_result_i(newr), .conv_data_i(data), .conv_pol_i(pol), .conv_ovr_i(ovr),
        .ce_n_i(ce_i), .hben_n_i(hb_i), .lben_n_i(lb_i),
        .ce_n_o(ce_o), .hben_n_o(hb_o), .lben_n_o(lb_o), .ctl_oe_o(ctl_oe),
        .bus_o(bus), .bus_oe_o(bus_oe)
    );

    function automatic logic [7:0] exp_hi(logic [11:0] d, logic p, logic o);
        return {2'b00, o, p, d[11:8]};
    endfunction

    function automatic logic [7:0] exp_lo(logic [11:0] d);
        return d[7:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: acts as the receiving byte register and measures pulse widths.
    int  ce_run = 0, hb_run = 0, lb_run = 0, hbus_run = 0, lbus_run = 0;
    int  ncap = 0, lb_rises = 0, stall_cnt = 0, stall_max = 0;
    logic [7:0] cap [2];

    always @(negedge clk) begin
        if (rst_n && ctl_oe) begin
            if (!ce_o) ce_run++;
            else if (ce_run != 0) begin
                check(ce_run == 2, "R6 load strobe width", ce_run, 2);
                check(bus_oe == 1'b1, "R7 byte on bus at strobe end", bus_oe, 1);
                if (ncap == 0) check(!hb_o, "R8 first byte flagged high", hb_o, 0);
                else           check(!lb_o, "R8 second byte flagged low", lb_o, 0);
                if (ncap < 2) cap[ncap] = bus;
                ncap++;
                ce_run = 0;
                if (stall_max > 0) begin
                    stall_cnt = $urandom_range(stall_max, 1);
                    uart_rdy = 1'b0;
                end
            end
            if (!hb_o) begin
                hb_run++;
                if (bus_oe) hbus_run++;
            end else if (hb_run != 0) begin
                check(hb_run == hbus_run + 1, "R7 high enable outlasts data", hb_run, hbus_run + 1);
                hb_run = 0; hbus_run = 0;
            end
            if (!lb_o) begin
                lb_run++;
                if (bus_oe) lbus_run++;
            end else if (lb_run != 0) begin
                check(lb_run == lbus_run + 1, "R6 low enable outlasts data", lb_run, lbus_run + 1);
                lb_run = 0; lbus_run = 0;
                lb_rises++;
            end
            if (!hb_o && !lb_o) check(0, "R8 both enables low", 0, 1);
        end
        if (stall_cnt > 0) begin
            stall_cnt--;
            if (stall_cnt == 0) uart_rdy = 1'b1;
        end
    end

    task automatic pulse_result(input logic [11:0] d, input logic p, input logic o);
        data = d; pol = p; ovr = o; newr = 1'b1;
        @(negedge clk);
        newr = 1'b0;
    endtask

    task automatic wait_done(input string tag, input logic [7:0] eh, input logic [7:0] el);
        int start = lb_rises;
        int guard = 0;
        while (lb_rises == start && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        check(ncap == 2, {tag, " byte count"}, ncap, 2);
        check(cap[0] == eh, {tag, " high byte"}, cap[0], eh);
        check(cap[1] == el, {tag, " low byte"}, cap[1], el);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [11:0] d;
        logic p, o;
        logic [11:0] keep_d;
        logic keep_p, keep_o;
        void'($urandom(32'h5eed_0042));
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ctl_oe == 1'b0, "R10 reset pins are inputs", ctl_oe, 0);
        check(bus_oe == 1'b0, "R2 reset bus quiet", bus_oe, 0);
        check({ce_o, hb_o, lb_o} == 3'b111, "R10 reset outputs high", {ce_o, hb_o, lb_o}, 7);

        // R1 / R2 passive mode with random selects
        d = 12'hA5C; p = 1; o = 0;
        pulse_result(d, p, o);
        for (int i = 0; i < 40; i++) begin
            logic eoe;
            logic [7:0] eb;
            if (i % 8 == 7) begin
                d = 12'($urandom); p = 1'($urandom); o = 1'($urandom);
                pulse_result(d, p, o);
            end
            {ce_i, hb_i, lb_i} = 3'($urandom);
            #(CLK_PERIOD/4);
            eoe = !ce_i && (!hb_i || !lb_i);
            eb  = !hb_i ? exp_hi(d, p, o) : exp_lo(d);
            check(bus_oe == eoe, "R2 passive bus enable", bus_oe, eoe);
            if (eoe) check(bus == eb, "R1 passive byte value", bus, eb);
            check(ctl_oe == 1'b0, "R2 pins stay inputs", ctl_oe, 0);
            @(negedge clk);
        end
        {ce_i, hb_i, lb_i} = 3'b111;

        // R4 mode edge triggers transfer of held result
        ncap = 0;
        mode = 1'b1;
        wait_done("R4 edge trigger", exp_hi(d, p, o), exp_lo(d));
        @(negedge clk);
        check({ce_o, hb_o, lb_o} == 3'b111 && ctl_oe, "R10 idle outputs high and driven",
              {ctl_oe, ce_o, hb_o, lb_o}, 4'hf);
        ncap = 0;
        wait_cycles(20);
        check(ncap == 0, "R4 no retrigger while mode stays high", ncap, 0);

        // R3 / R7 automatic transfers with random receiver stalls
        for (int k = 0; k < 8; k++) begin
            d = 12'($urandom); p = 1'($urandom); o = 1'($urandom);
            stall_max = (k == 0) ? 0 : int'($urandom_range(6, 1));
            ncap = 0;
            pulse_result(d, p, o);
            wait_done("R3 auto transfer", exp_hi(d, p, o), exp_lo(d));
            wait_cycles(3);
        end

        // R5 SEND low at entry holds the sequence
        stall_max = 0;
        hold_send = 1'b1;
        ncap = 0;
        d = 12'h3C1; p = 0; o = 1;
        pulse_result(d, p, o);
        wait_cycles(12);
        check(ncap == 0 && ce_o && hb_o, "R5 no strobe while SEND low", {ncap[1:0], ce_o, hb_o}, 3);
        check(ctl_oe == 1'b1, "R5 handshake entered", ctl_oe, 1);
        hold_send = 1'b0;
        wait_done("R5 after SEND high", exp_hi(d, p, o), exp_lo(d));
        wait_cycles(2);

        // R9 / R4 result during transfer is lost, mode toggles ignored
        stall_max = 8;
        ncap = 0;
        keep_d = 12'h7E2; keep_p = 1; keep_o = 1;
        pulse_result(keep_d, keep_p, keep_o);
        while (ncap < 1) @(negedge clk);
        pulse_result(12'h155, 0, 0);
        mode = 1'b0;
        @(negedge clk);
        mode = 1'b1;
        wait_done("R9 transfer unchanged", exp_hi(keep_d, keep_p, keep_o), exp_lo(keep_d));
        stall_max = 0;
        ncap = 0;
        wait_cycles(20);
        check(ncap == 0, "R4 mode toggle during transfer ignored", ncap, 0);
        mode = 1'b0;
        @(negedge clk);
        check(ctl_oe == 1'b0, "R10 pins revert when mode low", ctl_oe, 0);
        ncap = 0;
        mode = 1'b1;
        wait_done("R9 late result lost", exp_hi(keep_d, keep_p, keep_o), exp_lo(keep_d));
        wait_cycles(2);

        // R4 edge during latch: start waits, new result is sent
        mode = 1'b0;
        @(negedge clk);
        ncap = 0;
        d = 12'hBD4; p = 0; o = 1;
        data = d; pol = p; ovr = o;
        newr = 1'b1; mode = 1'b1;
        wait_cycles(3);
        check(hb_o && ce_o, "R4 no start during latch", {hb_o, ce_o}, 3);
        newr = 1'b0;
        wait_done("R4 deferred start", exp_hi(d, p, o), exp_lo(d));
        mode = 1'b0;
        wait_cycles(2);
        check(ctl_oe == 1'b0, "R10 inputs after final transfer", ctl_oe, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule